// File: doc/BRIEF.md
# Dispatch Classifier and Router

This block sits between register rename and the execution back end of an out-of-order core. Each cycle it receives a group of up to `N` renamed instructions, one per slot, each carrying a valid bit, a squashed flag and four type bits (load, store, non-speculative, nop). It walks the slots in slot order. For each instruction it decides which destination queues receive it, and it produces one enqueue strobe per slot for every destination. The queues themselves live outside the block, so only the strobes leave it.

The block is given the number of free issue-queue entries. It charges every issue-queue insert in the group against that budget. When it reaches a live instruction and no entry is left, it stops for the rest of the group. It then raises a stall toward rename and reports how many valid slots were left unhandled, so upstream can replay them. Statistics counters record what was dispatched, and a registered copy of the post-dispatch free count is sent upstream every cycle.

Top module: `dispatch_router`

## Requirements
- R1: A valid slot with the squashed flag set, reached before any stop, raises no strobe and takes no issue-queue entry. It adds one to the squash counter on the next clock edge. It is dropped even when the budget is zero, because the squashed check comes before the full check.
- R2: When a valid, non-squashed slot is reached with zero remaining budget, that slot and every later slot raise no strobe. `stall_o` is high in the same cycle, and `left_cnt_o` equals the number of valid slots from the stopping slot onward, squashed ones included. The full-event counter rises by exactly one on the next edge. With no stop, `stall_o` is low and `left_cnt_o` is 0.
- R3: A load raises its load-queue strobe together with its issue-queue strobe. A store raises its store-queue strobe together with its issue-queue strobe. When several type bits are set, the first match in the order load, store, non-speculative, nop decides the route.
- R4: A non-speculative instruction raises only its non-speculative strobe and its can-commit mark. It takes no issue-queue entry.
- R5: A nop raises its tail-advance strobe, its issued/executed mark and its can-commit mark, and nothing else. It takes no issue-queue entry.
- R6: An instruction with no type bit set raises only its issue-queue strobe.
- R7: Issue-queue inserts earlier in the same group reduce the budget seen by later slots, so the number of issue-queue strobes in a cycle never exceeds `iq_free_i`.
- R8: The dispatched, load, store and non-speculative counters each rise on the next edge by the number of issue-queue, load-queue, store-queue and non-speculative strobes of the cycle.
- R9: `free_up_o` equals, one cycle later, `iq_free_i` minus the number of issue-queue strobes of that cycle.
- R10: Slots whose valid bit is low are skipped and raise nothing. After reset all counters and `free_up_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | N | Slot holds an instruction |
| in_squash_i | input | N | Instruction has been squashed |
| in_load_i | input | N | Instruction is a load |
| in_store_i | input | N | Instruction is a store |
| in_nonspec_i | input | N | Instruction must run non-speculatively |
| in_nop_i | input | N | Instruction is a nop |
| iq_free_i | input | $clog2(IQ_DEPTH+1) | Free issue-queue entries this cycle |
| iq_enq_o | output | N | Issue-queue enqueue strobe per slot |
| ldq_enq_o | output | N | Load-queue enqueue strobe per slot |
| stq_enq_o | output | N | Store-queue enqueue strobe per slot |
| nsq_enq_o | output | N | Non-speculative enqueue strobe per slot |
| tail_adv_o | output | N | Issue-queue tail advance for a completed nop |
| mark_done_o | output | N | Mark instruction issued and executed |
| mark_commit_o | output | N | Mark instruction ready to commit |
| stall_o | output | 1 | Stall request to rename, group cut short |
| left_cnt_o | output | $clog2(N+1) | Valid slots not handled this cycle |
| free_up_o | output | $clog2(IQ_DEPTH+1) | Registered free-entry count sent upstream |
| cnt_disp_o | output | CNT_W | Issue-queue inserts |
| cnt_squash_o | output | CNT_W | Squashed instructions dropped |
| cnt_load_o | output | CNT_W | Loads dispatched |
| cnt_store_o | output | CNT_W | Stores dispatched |
| cnt_nonspec_o | output | CNT_W | Non-speculative instructions dispatched |
| cnt_full_o | output | CNT_W | Cycles that stopped on a full issue queue |

## Verification
The bench first targets the budget boundary, where inserts inside the group drain the free count to zero part way through. A design that checked only the start-of-cycle full flag would over-fill the queue, and one that stopped one slot late would show up in the strobes and in `left_cnt_o`. Groups that put a squashed instruction at a zero budget, and squashed instructions behind a stop, check the order of the squashed and full tests. A swapped order would stall on a dropped instruction or count squashes that were never examined. Groups that mix nops, non-speculative instructions and multi-type instructions show whether either kind wrongly takes an issue-queue entry and whether the type priority holds. Invalid holes between slots check that empty slots neither stop the group nor count as left over.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef enum logic [2:0] {
        RT_NONE    = 3'd0,
        RT_DROP    = 3'd1,
        RT_PLAIN   = 3'd2,
        RT_LOAD    = 3'd3,
        RT_STORE   = 3'd4,
        RT_NONSPEC = 3'd5,
        RT_NOP     = 3'd6
    } route_e;

    typedef struct packed {
        logic valid;
        logic squash;
        logic ld;
        logic st;
        logic ns;
        logic nop;
    } slot_t;

    typedef struct packed {
        logic iq;
        logic ldq;
        logic stq;
        logic nsq;
        logic tail;
        logic done;
        logic commit;
    } strobe_t;

    // Type priority: load, store, non-speculative, nop, otherwise plain.
    function automatic route_e classify(slot_t s);
        if (!s.valid)      return RT_NONE;
        else if (s.squash) return RT_DROP;
        else if (s.ld)     return RT_LOAD;
        else if (s.st)     return RT_STORE;
        else if (s.ns)     return RT_NONSPEC;
        else if (s.nop)    return RT_NOP;
        else               return RT_PLAIN;
    endfunction

    function automatic logic takes_iq(route_e r);
        return (r == RT_PLAIN) || (r == RT_LOAD) || (r == RT_STORE);
    endfunction

    function automatic strobe_t route_strobes(route_e r);
        strobe_t s;
        s = '0;
        case (r)
            RT_PLAIN:   s.iq = 1'b1;
            RT_LOAD:    begin s.iq = 1'b1; s.ldq = 1'b1; end
            RT_STORE:   begin s.iq = 1'b1; s.stq = 1'b1; end
            RT_NONSPEC: begin s.nsq = 1'b1; s.commit = 1'b1; end
            RT_NOP:     begin s.tail = 1'b1; s.done = 1'b1; s.commit = 1'b1; end
            default:    s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/disp_slot_decode.sv
module disp_slot_decode
    import disp_pkg::*;
(
    input  slot_t  slot_i,
    output route_e route_o
);
    always_comb route_o = classify(slot_i);
endmodule

// File: rtl/disp_order_scan.sv
module disp_order_scan
    import disp_pkg::*;
#(
    parameter int N      = 4,
    parameter int FREE_W = 6,
    parameter int CW     = 3
) (
    input  route_e              route_i [N],
    input  logic [FREE_W-1:0]   free_i,
    output strobe_t             str_o   [N],
    output logic [N-1:0]        drop_o,
    output logic                stop_o,
    output logic [CW-1:0]       left_o,
    output logic [CW-1:0]       used_o
);
    always_comb begin : scan
        logic [FREE_W-1:0] budget;
        logic              halted;
        budget = free_i;
        halted = 1'b0;
        left_o = '0;
        used_o = '0;
        drop_o = '0;
        for (int i = 0; i < N; i++) begin
            str_o[i] = '0;
            if (route_i[i] != RT_NONE) begin
                if (halted) begin
                    left_o = left_o + CW'(1);
                end else if (route_i[i] == RT_DROP) begin
                    drop_o[i] = 1'b1;
                end else if (budget == '0) begin
                    halted = 1'b1;
                    left_o = left_o + CW'(1);
                end else begin
                    str_o[i] = route_strobes(route_i[i]);
                    if (takes_iq(route_i[i])) begin
                        budget = budget - FREE_W'(1);
                        used_o = used_o + CW'(1);
                    end
                end
            end
        end
        stop_o = halted;
    end
endmodule

// File: rtl/disp_stat_counters.sv
module disp_stat_counters #(
    parameter int N     = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     iq_i,
    input  logic [N-1:0]     ldq_i,
    input  logic [N-1:0]     stq_i,
    input  logic [N-1:0]     nsq_i,
    input  logic [N-1:0]     drop_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] disp_o,
    output logic [CNT_W-1:0] squash_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] store_o,
    output logic [CNT_W-1:0] nonspec_o,
    output logic [CNT_W-1:0] full_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            disp_o    <= '0;
            squash_o  <= '0;
            load_o    <= '0;
            store_o   <= '0;
            nonspec_o <= '0;
            full_o    <= '0;
        end else begin
            disp_o    <= disp_o    + CNT_W'($countones(iq_i));
            squash_o  <= squash_o  + CNT_W'($countones(drop_i));
            load_o    <= load_o    + CNT_W'($countones(ldq_i));
            store_o   <= store_o   + CNT_W'($countones(stq_i));
            nonspec_o <= nonspec_o + CNT_W'($countones(nsq_i));
            full_o    <= full_o    + CNT_W'(stop_i);
        end
    end

    p_full_event_r2: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> full_o == $past(full_o) + CNT_W'(1));
    p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !stop_i |=> $stable(full_o));
    p_load_count_r8: assert property (@(posedge clk) disable iff (rst)
        (ldq_i == '0) |=> $stable(load_o));
endmodule

// File: rtl/dispatch_router.sv
module dispatch_router
    import disp_pkg::*;
#(
    parameter int N        = 4,
    parameter int IQ_DEPTH = 32,
    parameter int CNT_W    = 16,
    localparam int FREE_W  = $clog2(IQ_DEPTH + 1),
    localparam int CW      = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      in_valid_i,
    input  logic [N-1:0]      in_squash_i,
    input  logic [N-1:0]      in_load_i,
    input  logic [N-1:0]      in_store_i,
    input  logic [N-1:0]      in_nonspec_i,
    input  logic [N-1:0]      in_nop_i,
    input  logic [FREE_W-1:0] iq_free_i,
    output logic [N-1:0]      iq_enq_o,
    output logic [N-1:0]      ldq_enq_o,
    output logic [N-1:0]      stq_enq_o,
    output logic [N-1:0]      nsq_enq_o,
    output logic [N-1:0]      tail_adv_o,
    output logic [N-1:0]      mark_done_o,
    output logic [N-1:0]      mark_commit_o,
    output logic              stall_o,
    output logic [CW-1:0]     left_cnt_o,
    output logic [FREE_W-1:0] free_up_o,
    output logic [CNT_W-1:0]  cnt_disp_o,
    output logic [CNT_W-1:0]  cnt_squash_o,
    output logic [CNT_W-1:0]  cnt_load_o,
    output logic [CNT_W-1:0]  cnt_store_o,
    output logic [CNT_W-1:0]  cnt_nonspec_o,
    output logic [CNT_W-1:0]  cnt_full_o
);
    route_e        routes [N];
    strobe_t       strobes [N];
    logic [N-1:0]  drops;
    logic [CW-1:0] used;

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_t s;
        assign s = '{valid: in_valid_i[g], squash: in_squash_i[g], ld: in_load_i[g],
                     st: in_store_i[g], ns: in_nonspec_i[g], nop: in_nop_i[g]};
        disp_slot_decode u_dec (.slot_i(s), .route_o(routes[g]));
        assign iq_enq_o[g]      = strobes[g].iq;
        assign ldq_enq_o[g]     = strobes[g].ldq;
        assign stq_enq_o[g]     = strobes[g].stq;
        assign nsq_enq_o[g]     = strobes[g].nsq;
        assign tail_adv_o[g]    = strobes[g].tail;
        assign mark_done_o[g]   = strobes[g].done;
        assign mark_commit_o[g] = strobes[g].commit;
    end

    disp_order_scan #(.N(N), .FREE_W(FREE_W), .CW(CW)) u_scan (
        .route_i (routes),
        .free_i  (iq_free_i),
        .str_o   (strobes),
        .drop_o  (drops),
        .stop_o  (stall_o),
        .left_o  (left_cnt_o),
        .used_o  (used)
    );

    disp_stat_counters #(.N(N), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .iq_i     (iq_enq_o),
        .ldq_i    (ldq_enq_o),
        .stq_i    (stq_enq_o),
        .nsq_i    (nsq_enq_o),
        .drop_i   (drops),
        .stop_i   (stall_o),
        .disp_o   (cnt_disp_o),
        .squash_o (cnt_squash_o),
        .load_o   (cnt_load_o),
        .store_o  (cnt_store_o),
        .nonspec_o(cnt_nonspec_o),
        .full_o   (cnt_full_o)
    );

    always_ff @(posedge clk) begin
        if (rst) free_up_o <= '0;
        else     free_up_o <= iq_free_i - FREE_W'(used);
    end

    p_sq_silent_r1: assert property (@(posedge clk) disable iff (rst)
        ((in_valid_i & in_squash_i) & (iq_enq_o | ldq_enq_o | stq_enq_o | nsq_enq_o | tail_adv_o)) == '0);
    p_stall_left_r2: assert property (@(posedge clk) disable iff (rst)
        stall_o == (left_cnt_o != '0));
    p_mem_in_iq_r3: assert property (@(posedge clk) disable iff (rst)
        ((ldq_enq_o | stq_enq_o) & ~iq_enq_o) == '0);
    p_ns_alone_r4: assert property (@(posedge clk) disable iff (rst)
        (nsq_enq_o & (iq_enq_o | ldq_enq_o | stq_enq_o | tail_adv_o)) == '0);
    p_nop_alone_r5: assert property (@(posedge clk) disable iff (rst)
        ((tail_adv_o & (iq_enq_o | nsq_enq_o)) == '0) && (mark_done_o == tail_adv_o));
    p_iq_limit_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(iq_enq_o) <= int'(iq_free_i));
    p_free_report_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> int'(free_up_o) == int'($past(iq_free_i)) - $past($countones(iq_enq_o)));
endmodule

// File: tb/dispatch_router_bench.sv
module dispatch_router_bench;
    localparam int N = 4;
    localparam int FREE_W = 6;
    localparam int CW = 3;
    localparam int CNT_W = 16;
    localparam time PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] v, sq, ld, st, ns, np;
    logic [FREE_W-1:0] free;
    logic [N-1:0] iq, ldq, stq, nsq, tail, done, cmt;
    logic stall;
    logic [CW-1:0] left;
    logic [FREE_W-1:0] free_up;
    logic [CNT_W-1:0] c_disp, c_sq, c_ld, c_st, c_ns, c_full;

    int n_checks = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    dispatch_router u_dispatch_router (
        .clk(clk), .rst(rst),
        .in_valid_i(v), .in_squash_i(sq), .in_load_i(ld), .in_store_i(st),
        .in_nonspec_i(ns), .in_nop_i(np), .iq_free_i(free),
        .iq_enq_o(iq), .ldq_enq_o(ldq), .stq_enq_o(stq), .nsq_enq_o(nsq),
        .tail_adv_o(tail), .mark_done_o(done), .mark_commit_o(cmt),
        .stall_o(stall), .left_cnt_o(left), .free_up_o(free_up),
        .cnt_disp_o(c_disp), .cnt_squash_o(c_sq), .cnt_load_o(c_ld),
        .cnt_store_o(c_st), .cnt_nonspec_o(c_ns), .cnt_full_o(c_full)
    );

    typedef struct {
        int disp; int sq; int ld; int st; int ns; int full; int fup;
    } regs_t;

    regs_t exp_q[$];
    regs_t model = '{0, 0, 0, 0, 0, 0, 0};

    task automatic check(string req, string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver: applies a group at the falling edge, checks the same-cycle
    // strobes, and queues the registered values due after the next edge.
    task automatic drive(logic [N-1:0] dv, logic [N-1:0] dsq, logic [N-1:0] dld,
                         logic [N-1:0] dst, logic [N-1:0] dns, logic [N-1:0] dnp, int dfree);
        logic [N-1:0] e_iq, e_ldq, e_stq, e_nsq, e_tail, e_cmt;
        int budget, e_left, n_drop, used;
        bit halted;
        @(negedge clk);
        v = dv; sq = dsq; ld = dld; st = dst; ns = dns; np = dnp; free = FREE_W'(dfree);
        e_iq = '0; e_ldq = '0; e_stq = '0; e_nsq = '0; e_tail = '0; e_cmt = '0;
        budget = dfree; e_left = 0; n_drop = 0; used = 0; halted = 0;
        for (int i = 0; i < N; i++) begin
            if (!dv[i]) continue;                          // R10
            if (halted) begin e_left++; continue; end      // R2
            if (dsq[i]) begin n_drop++; continue; end      // R1
            if (budget == 0) begin halted = 1; e_left++; continue; end
            if (dld[i])      begin e_iq[i] = 1; e_ldq[i] = 1; end          // R3
            else if (dst[i]) begin e_iq[i] = 1; e_stq[i] = 1; end
            else if (dns[i]) begin e_nsq[i] = 1; e_cmt[i] = 1; end         // R4
            else if (dnp[i]) begin e_tail[i] = 1; e_cmt[i] = 1; end        // R5
            else e_iq[i] = 1;                                              // R6
            if (e_iq[i]) begin budget--; used++; end                       // R7
        end
        #1;
        check("R6,R7", "iq_enq", int'(iq), int'(e_iq));
        check("R3", "ldq_enq", int'(ldq), int'(e_ldq));
        check("R3", "stq_enq", int'(stq), int'(e_stq));
        check("R4", "nsq_enq", int'(nsq), int'(e_nsq));
        check("R5", "tail_adv", int'(tail), int'(e_tail));
        check("R5", "mark_done", int'(done), int'(e_tail));
        check("R4,R5", "mark_commit", int'(cmt), int'(e_cmt));
        check("R2", "stall", int'(stall), int'(halted));
        check("R2", "left_cnt", int'(left), e_left);
        model.disp += $countones(e_iq);
        model.sq   += n_drop;
        model.ld   += $countones(e_ldq);
        model.st   += $countones(e_stq);
        model.ns   += $countones(e_nsq);
        model.full += int'(halted);
        model.fup   = dfree - used;
        exp_q.push_back(model);
    endtask

    // Monitor: registered outputs compared just after each rising edge.
    initial begin
        regs_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check("R8", "cnt_disp", int'(c_disp), e.disp);
                check("R1", "cnt_squash", int'(c_sq), e.sq);
                check("R8", "cnt_load", int'(c_ld), e.ld);
                check("R8", "cnt_store", int'(c_st), e.st);
                check("R8", "cnt_nonspec", int'(c_ns), e.ns);
                check("R2", "cnt_full", int'(c_full), e.full);
                check("R9", "free_up", int'(free_up), e.fup);
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        v = '0; sq = '0; ld = '0; st = '0; ns = '0; np = '0; free = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset cnt_disp", int'(c_disp), 0);
        check("R10", "reset cnt_full", int'(c_full), 0);
        check("R10", "reset free_up", int'(free_up), 0);
        rst = 1'b0;
        // all plain, ample room
        drive(4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 10);
        // load, store, non-spec, nop in slots 0..3
        drive(4'b1111, 4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 10);
        // budget runs out after two inserts (R7)
        drive(4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2);
        // squashed slot at zero budget dropped, next slot stops (R1, R2)
        drive(4'b1111, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0);
        // non-spec and nop spend nothing; one entry for slot 2, slot 3 stops
        drive(4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0010, 1);
        // holes in the group (R10)
        drive(4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1);
        // load and store both set: load wins (R3)
        drive(4'b0001, 4'b0000, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 5);
        // squashed behind a stop is not counted as dropped
        drive(4'b1111, 4'b1110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0);
        // exact fit: four inserts, four entries
        drive(4'b1111, 4'b0000, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 4);
        // empty group
        drive(4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 7);
        for (int k = 0; k < 300; k++) begin
            drive(N'($urandom), N'($urandom & $urandom), N'($urandom & $urandom),
                  N'($urandom & $urandom), N'($urandom & $urandom),
                  N'($urandom & $urandom), int'($urandom_range(0, 6)));
        end
        @(negedge clk);
        v = '0;
        repeat (2) @(posedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule